// File: doc/BRIEF.md
# Gated Timer/Counter Channel with Selectable Time Base

This block is one timer/counter channel of the kind found next to a small CPU core. It keeps its count in two byte registers, a high byte and a low byte. Software can write each byte on its own. The channel counts in one of two ways. It can count ticks of an internal time base, which divides the clock by 12 or by 4. It can instead count falling edges seen on an external count pin.

A run bit starts and stops the channel. An optional gate qualifier makes counting also depend on an external gate level. A two-bit mode field sets how the count wraps:
- a 13-bit counter,
- a full 16-bit counter,
- an 8-bit counter that reloads itself from the high byte,
- a hold setting.

A sticky overflow flag records every wrap. It stays set until a clear strobe or an interrupt-acknowledge strobe removes it.

One time-base period is called a machine cycle. The external pin is sampled once per machine cycle. An edge that is found in one machine cycle adds to the count in the next one.

Top module: `tmr_chan`

## Requirements
- R1: While `rst_n` is low at a clock edge, both count bytes and the overflow flag become zero. The internal divider is also cleared, and the stored pin sample is set to high.
- R2: The time base emits one tick every 12 clocks when `fast_sel` is 0 and every 4 clocks when it is 1. In timer mode (`src_sel`=0), counting starts with the first tick after reset: the count changes at the 12th (or 4th) rising edge after reset is released.
- R3: An increment happens only when `run` is 1 and either `gate_en` is 0 or `gate_lvl` is 1. Otherwise both bytes hold.
- R4: With `src_sel`=1, `ext_pin` is sampled on every tick. A sample of 0 that follows a sample of 1 marks one falling edge. The count goes up by one on the next tick, not on the tick that found the edge. A pin held low adds nothing more.
- R5: `mode`=2'b00 counts 13 bits: the high byte holds the upper 8 bits and low-byte bits [4:0] hold the lower 5. Low-byte bits [7:5] are never changed by counting. The step from 0x1FFF to 0x0000 sets the overflow flag.
- R6: `mode`=2'b01 counts the full 16-bit value {high, low}. The step from 0xFFFF to 0x0000 sets the overflow flag.
- R7: `mode`=2'b10 counts only the low byte. An increment while it holds 0xFF loads the high-byte value into it and sets the overflow flag. The high byte is unchanged.
- R8: `mode`=2'b11 never counts. Both bytes change only by software writes.
- R9: The overflow flag is sticky. It is cleared by a cycle with `flag_clr` or `irq_ack` high. If a wrap happens in the same cycle as a clear, the flag ends up set.
- R10: A write to either byte is applied in its cycle, and it cancels any increment due in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 0 counts time-base ticks, 1 counts external falling edges |
| gate_en | input | 1 | When 1, counting also requires `gate_lvl` high |
| run | input | 1 | Run enable |
| gate_lvl | input | 1 | External gate level |
| ext_pin | input | 1 | External count pin (synchronous to `clk`) |
| fast_sel | input | 1 | Time-base select: 0 divides by 12, 1 divides by 4 |
| mode | input | 2 | Width mode: 00 13-bit, 01 16-bit, 10 8-bit reload, 11 hold |
| hi_we | input | 1 | Write strobe for the high byte |
| lo_we | input | 1 | Write strobe for the low byte |
| wr_data | input | 8 | Write data for either byte |
| flag_clr | input | 1 | Software clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, also clears the flag |
| hi_q | output | 8 | High count byte |
| lo_q | output | 8 | Low count byte |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Some properties are checked on every clock cycle:
- ticks never occur back to back;
- the edge pending bit only changes on a tick;
- the count holds while the channel is stopped or in hold mode;
- the upper three low-byte bits survive in 13-bit mode;
- a written byte takes the written value;
- the overflow flag is set, held and cleared as R9 says.

The bench scenarios cover what needs counted timing or known values:
- the exact tick spacing for each divider;
- the wrap values in each mode;
- the reload value in 8-bit mode;
- the one-machine-cycle delay between finding a pin edge and counting it;
- a write landing on the same edge as a tick.

// File: rtl/tmr_pkg.sv
// Shared encodings for the timer/counter channel.
package tmr_pkg;
    // Width mode field values; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        MODE_W13    = 2'b00,
        MODE_W16    = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_HOLD   = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
// Time-base divider. Produces a single-clock tick every SLOW_DIV clocks,
// or every FAST_DIV clocks when fast_sel is high.
// Assumes FAST_DIV >= 2 and SLOW_DIV >= FAST_DIV. A change of fast_sel
// takes effect mid-period: a count already past the new limit ticks at once.
module tmr_prescale #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick
);
    localparam int CW = $clog2(SLOW_DIV);

    logic [CW-1:0] div_q;
    logic [CW-1:0] last_val;

    // Terminal value of the divider for the selected time base.
    assign last_val = fast_sel ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    assign tick     = (div_q >= last_val);

    // Free-running divider that restarts after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + CW'(1);
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_edge_det.sv
// External falling-edge finder. Samples the pin once per tick. A high sample
// followed by a low sample leaves an edge pending. The pending bit is consumed
// on the following tick, which delays the count by one machine cycle.
// Assumes ext_pin is already synchronous to clk.
module tmr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ext_pin,
    output logic edge_pend
);
    logic smp_q;

    // Per-tick pin sample and edge detection; the sample history resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q     <= 1'b1;
            edge_pend <= 1'b0;
        end else if (tick) begin
            smp_q     <= ext_pin;
            edge_pend <= smp_q & ~ext_pin;
        end
    end

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(edge_pend));
endmodule

// File: rtl/tmr_count.sv
// Count register pair with mode-dependent wrap, reload and sticky overflow.
// Assumes inc is a single-cycle request. A byte write in the same cycle
// cancels the request entirely.
module tmr_count
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LOW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              inc,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              irq_ack,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              ovf
);
    localparam int NW13 = BYTE_W + LOW_W;
    localparam int NW16 = 2 * BYTE_W;

    logic              step;
    logic              wrap;
    logic [BYTE_W-1:0] hi_n, lo_n;
    logic [NW13:0]     sum13;
    logic [NW16:0]     sum16;

    // A write in this cycle wins over the increment; hold mode never steps.
    assign step  = inc && !hi_we && !lo_we && (mode != MODE_HOLD);
    assign sum13 = {1'b0, hi_q, lo_q[LOW_W-1:0]} + (NW13+1)'(1);
    assign sum16 = {1'b0, hi_q, lo_q} + (NW16+1)'(1);

    // Next-state selection per mode, then the byte writes on top.
    always_comb begin
        hi_n = hi_q;
        lo_n = lo_q;
        wrap = 1'b0;
        if (step) begin
            unique case (mode)
                MODE_W13: begin
                    hi_n              = sum13[NW13-1:LOW_W];
                    lo_n[LOW_W-1:0]   = sum13[LOW_W-1:0];
                    wrap              = sum13[NW13];
                end
                MODE_W16: begin
                    hi_n = sum16[NW16-1:BYTE_W];
                    lo_n = sum16[BYTE_W-1:0];
                    wrap = sum16[NW16];
                end
                MODE_RELOAD: begin
                    if (&lo_q) begin
                        lo_n = hi_q;
                        wrap = 1'b1;
                    end else begin
                        lo_n = lo_q + BYTE_W'(1);
                    end
                end
                default: ;
            endcase
        end
        if (hi_we) hi_n = wr_data;
        if (lo_we) lo_n = wr_data;
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    // Sticky overflow flag; a wrap beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovf <= 1'b0;
        else if (wrap)                ovf <= 1'b1;
        else if (flag_clr || irq_ack) ovf <= 1'b0;
    end

    // R5
    lo_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_W13 && !lo_we) |=> lo_q[BYTE_W-1:LOW_W] == $past(lo_q[BYTE_W-1:LOW_W]));
    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && !hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> lo_q == $past(wr_data));
    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf);
    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && (flag_clr || irq_ack)) |=> !ovf);
    // R9
    no_spurious_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !wrap) |=> !ovf);
endmodule

// File: rtl/tmr_chan.sv
// Timer/counter channel top. Combines the time-base divider, the external
// edge finder and the count registers. It forms the increment request from
// the run bit, the gate qualifier and the source select.
// Assumes all inputs, ext_pin and gate_lvl included, are synchronous to clk.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int LOW_W    = 5,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic              gate_en,
    input  logic              run,
    input  logic              gate_lvl,
    input  logic              ext_pin,
    input  logic              fast_sel,
    input  logic [1:0]        mode,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    input  logic              irq_ack,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              ovf
);
    logic tick;
    logic edge_pend;
    logic enabled;
    logic inc_req;

    tmr_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fast_sel),
        .tick     (tick)
    );

    tmr_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ext_pin   (ext_pin),
        .edge_pend (edge_pend)
    );

    // Run and gate qualification, then the per-source increment request.
    assign enabled = run && (!gate_en || gate_lvl);
    assign inc_req = tick && enabled && (src_sel ? edge_pend : 1'b1);

    tmr_count #(.BYTE_W(BYTE_W), .LOW_W(LOW_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (tmr_mode_e'(mode)),
        .inc      (inc_req),
        .hi_we    (hi_we),
        .lo_we    (lo_we),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .irq_ack  (irq_ack),
        .hi_q     (hi_q),
        .lo_q     (lo_q),
        .ovf      (ovf)
    );

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
    typedef struct packed {
        logic [1:0] mode;
        logic       fast;
        logic [7:0] hi0;
        logic [7:0] lo0;
        logic [7:0] edges;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic       eovf;
    } vec_t;

    // edges = rising edges after reset release; the bytes are written on edges 1 and 2.
    localparam vec_t VECS [7] = '{
        '{2'd1, 1'b1, 8'hFF, 8'hFE, 8'd8,   8'h00, 8'h00, 1'b1},  // R6 wrap
        '{2'd1, 1'b0, 8'h12, 8'h34, 8'd36,  8'h12, 8'h37, 1'b0},  // R6, R2 slow base
        '{2'd0, 1'b1, 8'hFF, 8'hE0, 8'd132, 8'h00, 8'hE1, 1'b1},  // R5 wrap, upper bits kept
        '{2'd0, 1'b1, 8'h00, 8'h5F, 8'd4,   8'h01, 8'h40, 1'b0},  // R5 carry into high byte
        '{2'd2, 1'b1, 8'hF0, 8'hFE, 8'd12,  8'hF0, 8'hF1, 1'b1},  // R7 reload
        '{2'd2, 1'b0, 8'h80, 8'h10, 8'd24,  8'h80, 8'h12, 1'b0},  // R7 no wrap
        '{2'd3, 1'b1, 8'h55, 8'hAA, 8'd20,  8'h55, 8'hAA, 1'b0}   // R8 hold
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b0, gate_en = 1'b0, run = 1'b1, gate_lvl = 1'b0;
    logic       ext_pin = 1'b1, fast_sel = 1'b1;
    logic [1:0] mode = 2'd1;
    logic       hi_we = 1'b0, lo_we = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] hi_q, lo_q;
    logic       ovf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_chan u_tmr_chan (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .gate_en(gate_en), .run(run),
        .gate_lvl(gate_lvl), .ext_pin(ext_pin), .fast_sel(fast_sel), .mode(mode),
        .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .hi_q(hi_q), .lo_q(lo_q), .ovf(ovf)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Leaves the bench at the falling edge just before the first edge after release.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit hi, input logic [7:0] d);
        hi_we = hi; lo_we = !hi; wr_data = d;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(5ns * 20000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        wr_data = 8'h3C; hi_we = 1'b1; lo_we = 1'b1;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
        chk("R1", "hi after reset", 16'(hi_q), 16'h00);
        chk("R1", "lo after reset", 16'(lo_q), 16'h00);
        chk("R1", "ovf after reset", 16'(ovf), 16'h0);

        // Vector table: modes, wraps and time bases
        foreach (VECS[i]) begin
            mode = VECS[i].mode; fast_sel = VECS[i].fast;
            src_sel = 1'b0; gate_en = 1'b0; run = 1'b1;
            do_reset();
            wr(1'b1, VECS[i].hi0);
            wr(1'b0, VECS[i].lo0);
            repeat (int'(VECS[i].edges) - 2) @(negedge clk);
            chk(mode_req(VECS[i].mode), $sformatf("vec %0d hi", i), 16'(hi_q), 16'(VECS[i].ehi));
            chk(mode_req(VECS[i].mode), $sformatf("vec %0d lo", i), 16'(lo_q), 16'(VECS[i].elo));
            chk("R9", $sformatf("vec %0d ovf", i), 16'(ovf), 16'(VECS[i].eovf));
        end

        // R2 slow time base: first count lands on edge 12
        mode = 2'd1; fast_sel = 1'b0;
        do_reset();
        repeat (11) @(negedge clk);
        chk("R2", "slow base before edge 12", 16'(lo_q), 16'h00);
        @(negedge clk);
        chk("R2", "slow base at edge 12", 16'(lo_q), 16'h01);
        // R2 fast time base: first count lands on edge 4
        fast_sel = 1'b1;
        do_reset();
        repeat (3) @(negedge clk);
        chk("R2", "fast base before edge 4", 16'(lo_q), 16'h00);
        @(negedge clk);
        chk("R2", "fast base at edge 4", 16'(lo_q), 16'h01);

        // R3 gate and run qualification
        gate_en = 1'b1; gate_lvl = 1'b0;
        do_reset();
        repeat (16) @(negedge clk);
        chk("R3", "gate low blocks", 16'(lo_q), 16'h00);
        gate_lvl = 1'b1;
        repeat (8) @(negedge clk);
        chk("R3", "gate high counts", 16'(lo_q), 16'h02);
        run = 1'b0;
        repeat (8) @(negedge clk);
        chk("R3", "run low holds", 16'(lo_q), 16'h02);
        run = 1'b1; gate_en = 1'b0; gate_lvl = 1'b0;

        // R4 external edges, counted one machine cycle late
        src_sel = 1'b1; ext_pin = 1'b1;
        do_reset();
        repeat (4) @(negedge clk);
        ext_pin = 1'b0;
        repeat (7) @(negedge clk);
        chk("R4", "edge seen but not yet counted", 16'(lo_q), 16'h00);
        @(negedge clk);
        chk("R4", "edge counted one tick later", 16'(lo_q), 16'h01);
        repeat (8) @(negedge clk);
        chk("R4", "held low adds nothing", 16'(lo_q), 16'h01);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        ext_pin = 1'b0;
        repeat (8) @(negedge clk);
        chk("R4", "second edge counted", 16'(lo_q), 16'h02);
        src_sel = 1'b0; ext_pin = 1'b1;

        // R10 write on the same edge as a tick
        do_reset();
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h77);
        chk("R10", "write beats increment", 16'(lo_q), 16'h77);
        chk("R10", "high byte untouched", 16'(hi_q), 16'h00);
        repeat (4) @(negedge clk);
        chk("R10", "counting resumes", 16'(lo_q), 16'h78);

        // R9 sticky flag, both clear paths, set beats clear
        do_reset();
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R9", "flag set on wrap", 16'(ovf), 16'h1);
        repeat (4) @(negedge clk);
        chk("R9", "flag sticky", 16'(ovf), 16'h1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R9", "software clear", 16'(ovf), 16'h0);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'hFF);
        @(negedge clk);
        chk("R9", "flag set again", 16'(ovf), 16'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R9", "ack clear", 16'(ovf), 16'h0);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'hFF);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R9", "wrap beats clear", 16'(ovf), 16'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule